// File: doc/BRIEF.md
# Capture-Compare 16-bit Timer

This block is a 16-bit timer/counter for general timing work. It is clocked by the system clock. A count event advances it. The event is either a one-cycle tick from an external prescaler or a chosen edge of an external timer pin. The counter can run upward and wrap at a selectable TOP value, or run up and down between zero and TOP. Three compare channels watch the counter. Each one raises a flag and can drive a waveform pin. One capture channel stores the counter value when an edge arrives on a capture pin or on a comparator input. That input can pass through a majority-free noise filter first.

Software reaches the block through a flat register port. Reads are combinational. The port holds the counter, the three compare values, the capture value, two 8-bit control words, a flag word and a mask word. Any flag whose mask bit is set asserts the single interrupt output.

Top module: `cct_timer`

## Requirements
- R1: After reset every register reads zero, all waveform outputs are low and `irq` is low.
- R2: Control word A bits [1:0] pick the count source: 0 none, 1 the `tickIn` level (one step per clock in which it is high), 2 rising edges of `extPin`, 3 falling edges of `extPin`. In modes 2 and 3 `tickIn` has no effect.
- R3: With source 0 the counter holds its value whatever `tickIn` or `extPin` do.
- R4: With control word A bit 4 clear, each count event increments the counter. When the counter equals TOP (or all ones), the event instead loads zero and sets flag bit 0 (overflow).
- R5: With control word A bit 4 set, the counter counts up to TOP, turns and counts down to zero, then turns up again. The event at zero loads one and sets flag bit 0.
- R6: Control word A bits [3:2] choose TOP: 0 gives 0xFFFF, 1 gives 0x00FF, 2 gives the channel A compare register, 3 gives the capture register.
- R7: A count event that occurs while the counter equals compare register k (k = 0,1,2 for A,B,C) sets flag bit k+1. A counter write alone sets no flag.
- R8: Control word B field [2k+1:2k] sets the mode of channel k on a match: 0 disconnected (output low, channel state kept), 1 toggle, 2 clear, 3 set.
- R9: The capture input is `capPin` when control word B bit 6 is 0, and `cmpIn` when it is 1. It triggers on rising edges when bit 7 is 1 and on falling edges when bit 7 is 0. Each trigger copies the counter into the capture register and sets flag bit 4.
- R10: With control word A bit 5 set, a capture level is accepted only after four consecutive equal samples, so pulses of three clocks or less are ignored. With the bit clear, a two-clock pulse captures.
- R11: Writing 1 to a flag bit clears it and writing 0 leaves it. A flag stays set until cleared and sets again only on a new event.
- R12: `irq` is high exactly when some flag bit and its mask bit are both set.
- R13: Register map: 0 counter, 1-3 compare A-C, 4 capture, 5 control A, 6 control B, 7 flags, 8 mask. Control words keep 8 bits, the mask keeps 5 bits, and the unused upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| tickIn | input | 1 | Prescaled internal count tick |
| extPin | input | 1 | External count pin (asynchronous) |
| capPin | input | 1 | Capture pin (asynchronous) |
| cmpIn | input | 1 | Comparator output used as capture source |
| waveOut | output | 3 | Compare-channel waveform outputs |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench sweeps several small TOP values in both counting modes and follows every step against an arithmetic model. This catches an off-by-one at the turnaround, a missing wrap at TOP, or an overflow flag raised at the wrong end of the up/down cycle. It checks edge polarity and source selection for both the count pin and the capture inputs. A design that mixed these up would capture on the wrong edge or accept an edge from the unselected input. Pulses just under and just over the filter length show whether the noise filter really needs four equal samples. Flag write-one-clear, partial clears and the masked interrupt are checked against their exact bits.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [1:0] {CLK_OFF, CLK_TICK, CLK_EXT_RISE, CLK_EXT_FALL} clkSel_e;
  typedef enum logic [1:0] {TOP_FULL, TOP_BYTE, TOP_CMPA, TOP_CAP} topSel_e;
  typedef enum logic [1:0] {WAVE_OFF, WAVE_TOGGLE, WAVE_CLEAR, WAVE_SET} waveMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic countEn;
    logic capEvt;
  } strobe_t;
endpackage

// File: rtl/cct_ctrl.sv
module cct_ctrl
  import cct_pkg::*;
#(
  parameter int SYNC = 2,
  parameter int FILT = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  clkSel_e clkSel,
  input  logic    noiseEn,
  input  logic    capSrc,
  input  logic    capRise,
  input  logic    tickIn,
  input  logic    extPin,
  input  logic    capPin,
  input  logic    cmpIn,
  output strobe_t strobe
);
  logic [SYNC-1:0] extSync, capSync;
  logic            extPrev;
  logic [FILT-1:0] capHist;
  logic            filtLvl, capPrev;
  logic            extS, capS, capRaw;

  assign extS   = extSync[SYNC-1];
  assign capS   = capSync[SYNC-1];
  assign capRaw = capSrc ? cmpIn : capPin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extSync <= '0;
      capSync <= '0;
      extPrev <= 1'b0;
      capHist <= '0;
      filtLvl <= 1'b0;
      capPrev <= 1'b0;
    end else begin
      extSync <= {extSync[SYNC-2:0], extPin};
      capSync <= {capSync[SYNC-2:0], capRaw};
      extPrev <= extS;
      capHist <= {capHist[FILT-2:0], capS};
      capPrev <= filtLvl;
      if (noiseEn) begin
        if (&capHist)      filtLvl <= 1'b1;
        else if (~|capHist) filtLvl <= 1'b0;
      end else begin
        filtLvl <= capS;
      end
    end
  end

  always_comb begin
    strobe = '0;
    unique case (clkSel)
      CLK_OFF:      strobe.countEn = 1'b0;
      CLK_TICK:     strobe.countEn = tickIn;
      CLK_EXT_RISE: strobe.countEn = extS & ~extPrev;
      CLK_EXT_FALL: strobe.countEn = ~extS & extPrev;
      default:      strobe.countEn = 1'b0;
    endcase
    strobe.capEvt = capRise ? (filtLvl & ~capPrev) : (~filtLvl & capPrev);
  end
endmodule

// File: rtl/cct_dp.sv
module cct_dp
  import cct_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 3,
  parameter int AW  = 4,
  parameter int SHORT_BITS = 8,
  localparam int NFLAG = NCH + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             regWe,
  input  logic [AW-1:0]    regAddr,
  input  logic [CW-1:0]    regWdata,
  output logic [CW-1:0]    regRdata,
  output clkSel_e          clkSel,
  output logic             noiseEn,
  output logic             capSrc,
  output logic             capRise,
  output logic [NCH-1:0]   waveOut,
  output logic             irq,
  output logic [CW-1:0]    cntQ,
  output logic [CW-1:0]    capQ,
  output logic [CW-1:0]    topVal,
  output logic [NFLAG-1:0] flagQ,
  output logic             upDown
);
  localparam logic [AW-1:0] A_CNT  = AW'(0);
  localparam logic [AW-1:0] A_CMP0 = AW'(1);
  localparam logic [AW-1:0] A_CAP  = AW'(NCH + 1);
  localparam logic [AW-1:0] A_CTLA = AW'(NCH + 2);
  localparam logic [AW-1:0] A_CTLB = AW'(NCH + 3);
  localparam logic [AW-1:0] A_FLAG = AW'(NCH + 4);
  localparam logic [AW-1:0] A_MASK = AW'(NCH + 5);
  localparam logic [CW-1:0] SHORT_TOP = CW'((1 << SHORT_BITS) - 1);

  logic [CW-1:0]    cmpQ [NCH];
  logic [7:0]       ctlA, ctlB;
  logic [NFLAG-1:0] maskQ;
  logic             dirDown, dirNext, ovfHit;
  logic [CW-1:0]    cntNext;
  logic [NCH-1:0]   cmpHit, waveQ;
  logic             wrCnt, wrCap, wrFlag;
  topSel_e          topSel;

  assign clkSel  = clkSel_e'(ctlA[1:0]);
  assign topSel  = topSel_e'(ctlA[3:2]);
  assign upDown  = ctlA[4];
  assign noiseEn = ctlA[5];
  assign capSrc  = ctlB[6];
  assign capRise = ctlB[7];

  assign wrCnt  = regWe && (regAddr == A_CNT);
  assign wrCap  = regWe && (regAddr == A_CAP);
  assign wrFlag = regWe && (regAddr == A_FLAG);

  always_comb begin
    unique case (topSel)
      TOP_FULL: topVal = '1;
      TOP_BYTE: topVal = SHORT_TOP;
      TOP_CMPA: topVal = cmpQ[0];
      TOP_CAP:  topVal = capQ;
      default:  topVal = '1;
    endcase
  end

  // next counter value and direction
  always_comb begin
    cntNext = cntQ;
    ovfHit  = 1'b0;
    dirNext = upDown ? dirDown : 1'b0;
    if (strobe.countEn) begin
      if (!upDown) begin
        if (cntQ == topVal || cntQ == '1) begin
          cntNext = '0;
          ovfHit  = 1'b1;
        end else begin
          cntNext = cntQ + 1'b1;
        end
      end else if (!dirDown) begin
        if (cntQ >= topVal) begin
          dirNext = 1'b1;
          cntNext = (cntQ == '0) ? cntQ : cntQ - 1'b1;
        end else begin
          cntNext = cntQ + 1'b1;
        end
      end else begin
        if (cntQ == '0) begin
          dirNext = 1'b0;
          ovfHit  = 1'b1;
          cntNext = (topVal == '0) ? '0 : CW'(1);
        end else begin
          cntNext = cntQ - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      capQ    <= '0;
      dirDown <= 1'b0;
      ctlA    <= '0;
      ctlB    <= '0;
      flagQ   <= '0;
      maskQ   <= '0;
    end else begin
      cntQ    <= wrCnt ? regWdata : cntNext;
      dirDown <= dirNext;
      if (strobe.capEvt)  capQ <= cntQ;
      else if (wrCap)     capQ <= regWdata;
      if (regWe && regAddr == A_CTLA) ctlA  <= regWdata[7:0];
      if (regWe && regAddr == A_CTLB) ctlB  <= regWdata[7:0];
      if (regWe && regAddr == A_MASK) maskQ <= regWdata[NFLAG-1:0];
      flagQ <= (flagQ & ~(wrFlag ? regWdata[NFLAG-1:0] : '0))
             | {strobe.capEvt, cmpHit, ovfHit};
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : gChan
    waveMode_e mode;
    assign mode      = waveMode_e'(ctlB[2*g +: 2]);
    assign cmpHit[g] = strobe.countEn && (cntQ == cmpQ[g]);
    assign waveOut[g] = (mode != WAVE_OFF) && waveQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpQ[g]  <= '0;
        waveQ[g] <= 1'b0;
      end else begin
        if (regWe && regAddr == AW'(A_CMP0 + g)) cmpQ[g] <= regWdata;
        if (cmpHit[g]) begin
          unique case (mode)
            WAVE_TOGGLE: waveQ[g] <= ~waveQ[g];
            WAVE_CLEAR:  waveQ[g] <= 1'b0;
            WAVE_SET:    waveQ[g] <= 1'b1;
            default:     waveQ[g] <= waveQ[g];
          endcase
        end
      end
    end
  end

  assign irq = |(flagQ & maskQ);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CNT:  regRdata = cntQ;
      A_CAP:  regRdata = capQ;
      A_CTLA: regRdata = CW'(ctlA);
      A_CTLB: regRdata = CW'(ctlB);
      A_FLAG: regRdata = CW'(flagQ);
      A_MASK: regRdata = CW'(maskQ);
      default: begin
        for (int i = 0; i < NCH; i++)
          if (regAddr == AW'(A_CMP0 + i)) regRdata = cmpQ[i];
      end
    endcase
  end
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 3,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           regWe,
  input  logic [AW-1:0]  regAddr,
  input  logic [CW-1:0]  regWdata,
  output logic [CW-1:0]  regRdata,
  input  logic           tickIn,
  input  logic           extPin,
  input  logic           capPin,
  input  logic           cmpIn,
  output logic [NCH-1:0] waveOut,
  output logic           irq
);
  strobe_t         strobe;
  clkSel_e         clkSel;
  logic            noiseEn, capSrc, capRise, upDown;
  logic [CW-1:0]   cntQ, capQ, topVal;
  logic [NCH+1:0]  flagQ;

  cct_ctrl #(.SYNC(2), .FILT(4)) uCtrl (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .noiseEn(noiseEn),
    .capSrc(capSrc), .capRise(capRise), .tickIn(tickIn), .extPin(extPin),
    .capPin(capPin), .cmpIn(cmpIn), .strobe(strobe)
  );

  cct_dp #(.CW(CW), .NCH(NCH), .AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .clkSel(clkSel), .noiseEn(noiseEn), .capSrc(capSrc), .capRise(capRise),
    .waveOut(waveOut), .irq(irq), .cntQ(cntQ), .capQ(capQ),
    .topVal(topVal), .flagQ(flagQ), .upDown(upDown)
  );
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk
  import cct_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 3,
  parameter int AW  = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           regWe,
  input logic [AW-1:0]  regAddr,
  input strobe_t        strobe,
  input logic [CW-1:0]  cntQ,
  input logic [CW-1:0]  capQ,
  input logic [CW-1:0]  topVal,
  input logic [NCH+1:0] flagQ,
  input logic           upDown
);
  logic wrCnt, wrFlag;
  assign wrCnt  = regWe && (regAddr == AW'(0));
  assign wrFlag = regWe && (regAddr == AW'(NCH + 4));

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countEn && !wrCnt) |=> $stable(cntQ)); // R3

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && !upDown && !wrCnt && cntQ != topVal && cntQ != '1)
      |=> cntQ == $past(cntQ) + 1'b1); // R4

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && !upDown && !wrCnt && cntQ == topVal)
      |=> (cntQ == '0) && flagQ[0]); // R4

  AST_UD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && upDown && !wrCnt && topVal != '0)
      |=> (cntQ == $past(cntQ) + 1'b1) || (cntQ == $past(cntQ) - 1'b1)); // R5

  AST_CAP_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capEvt |=> (capQ == $past(cntQ)) && flagQ[NCH+1]); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[0] && !wrFlag) |=> flagQ[0]); // R11
endmodule

bind cct_timer cct_timer_chk #(.CW(CW), .NCH(NCH), .AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .strobe(strobe), .cntQ(cntQ), .capQ(capQ), .topVal(topVal),
  .flagQ(flagQ), .upDown(upDown)
);

// File: tb/cct_timer_test.sv
`timescale 1ns/1ps
module cct_timer_test;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        tickIn = 1'b0, extPin = 1'b0, capPin = 1'b0, cmpIn = 1'b0;
  logic [2:0]  waveOut;
  logic        irq;
  int checks = 0, fails = 0;
  logic [15:0] rv;

  localparam logic [3:0] CNT = 0, CMPA = 1, CMPB = 2, CMPC = 3, CAP = 4,
                         CTLA = 5, CTLB = 6, FLAG = 7, MASK = 8;

  cct_timer uut (.clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .tickIn(tickIn), .extPin(extPin),
    .capPin(capPin), .cmpIn(cmpIn), .waveOut(waveOut), .irq(irq));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk) tickIn = 1'b1;
      @(negedge clk) tickIn = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseCap(input bit onCmp, input int width);
    @(negedge clk);
    if (onCmp) cmpIn = 1'b1; else capPin = 1'b1;
    repeat (width) @(negedge clk);
    cmpIn = 1'b0; capPin = 1'b0;
    idle(14);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] expCnt;
    logic        dirDn, ovf;
    int          tops [4];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a <= 8; a++) begin
      rd(4'(a), rv); check("R1 reset reg", rv, 16'h0);
    end
    check("R1 reset waves", {13'b0, waveOut}, 16'h0);
    check("R1 reset irq", {15'b0, irq}, 16'h0);

    // R13 register widths
    wr(CTLA, 16'hABCD); rd(CTLA, rv); check("R13 ctlA width", rv, 16'h00CD);
    wr(CTLA, 16'h0000);
    wr(CMPB, 16'hBEEF); rd(CMPB, rv); check("R13 cmpB rw", rv, 16'hBEEF);
    wr(MASK, 16'hFFFF); rd(MASK, rv); check("R13 mask width", rv, 16'h001F);
    wr(MASK, 16'h0000);

    // R4/R6 up-mode sweep with TOP from compare A
    tops = '{1, 2, 5, 9};
    foreach (tops[t]) begin
      wr(CTLA, 16'h0); wr(CNT, 16'h0); wr(CMPA, 16'(tops[t])); wr(FLAG, 16'h1F);
      wr(CTLA, 16'h0009);
      expCnt = 0; ovf = 0;
      for (int k = 0; k < 2 * (tops[t] + 1) + 1; k++) begin
        tick(1);
        if (expCnt == 16'(tops[t])) begin expCnt = 0; ovf = 1; end
        else expCnt = expCnt + 1'b1;
        rd(CNT, rv); check("R4 up count", rv, expCnt);
      end
      rd(FLAG, rv); check("R4 overflow flag", {15'b0, rv[0]}, {15'b0, ovf});
    end

    // R6 fixed TOP values and capture-register TOP
    wr(CTLA, 16'h0); wr(CNT, 16'h00FE); wr(CTLA, 16'h0005);
    tick(1); rd(CNT, rv); check("R6 byte top step", rv, 16'h00FF);
    tick(1); rd(CNT, rv); check("R6 byte top wrap", rv, 16'h0000);
    wr(CTLA, 16'h0); wr(CNT, 16'hFFFE); wr(CTLA, 16'h0001);
    tick(1); rd(CNT, rv); check("R6 full top step", rv, 16'hFFFF);
    tick(1); rd(CNT, rv); check("R6 full top wrap", rv, 16'h0000);
    wr(CTLA, 16'h0); wr(CAP, 16'h0003); wr(CNT, 16'h0); wr(CTLA, 16'h000D);
    tick(3); rd(CNT, rv); check("R6 cap top reach", rv, 16'h0003);
    tick(1); rd(CNT, rv); check("R6 cap top wrap", rv, 16'h0000);

    // R5 up/down sweep
    tops = '{1, 3, 4, 6};
    foreach (tops[t]) begin
      wr(CTLA, 16'h0); wr(CNT, 16'h0); wr(CMPA, 16'(tops[t])); wr(FLAG, 16'h1F);
      wr(CTLA, 16'h0019);
      expCnt = 0; dirDn = 0; ovf = 0;
      for (int k = 0; k < 5 * tops[t] + 2; k++) begin
        tick(1);
        if (!dirDn) begin
          if (expCnt >= 16'(tops[t])) begin dirDn = 1; expCnt = expCnt - 1'b1; end
          else expCnt = expCnt + 1'b1;
        end else if (expCnt == 0) begin
          dirDn = 0; ovf = 1; expCnt = 1;
        end else expCnt = expCnt - 1'b1;
        rd(CNT, rv); check("R5 updown count", rv, expCnt);
      end
      rd(FLAG, rv); check("R5 bottom flag", {15'b0, rv[0]}, {15'b0, ovf});
    end

    // R3 no source: counter holds
    wr(CTLA, 16'h0); wr(CNT, 16'h0042);
    @(negedge clk) tickIn = 1'b1; extPin = 1'b1;
    idle(6); tickIn = 1'b0; extPin = 1'b0; idle(6);
    rd(CNT, rv); check("R3 hold without source", rv, 16'h0042);

    // R2 external rising and falling edges, tick ignored
    wr(CNT, 16'h0); wr(CTLA, 16'h0002);
    @(negedge clk) tickIn = 1'b1;
    repeat (5) begin
      extPin = 1'b1; idle(4); extPin = 1'b0; idle(4);
    end
    tickIn = 1'b0; idle(6);
    rd(CNT, rv); check("R2 rising edge count", rv, 16'h0005);
    wr(CTLA, 16'h0); wr(CNT, 16'h0); wr(CTLA, 16'h0003);
    repeat (3) begin
      @(negedge clk) extPin = 1'b1; idle(4); extPin = 1'b0; idle(4);
    end
    idle(6);
    rd(CNT, rv); check("R2 falling edge count", rv, 16'h0003);
    wr(CTLA, 16'h0); wr(CNT, 16'h0); wr(CTLA, 16'h0001);
    tick(7); rd(CNT, rv); check("R2 tick count", rv, 16'h0007);

    // R7/R8 compare flags and waveform modes
    wr(CTLA, 16'h0); wr(CNT, 16'h0);
    wr(CMPA, 16'h2); wr(CMPB, 16'h3); wr(CMPC, 16'h5);
    wr(CTLB, 16'h003D); wr(FLAG, 16'h1F);
    wr(CTLA, 16'h0001);
    for (int k = 1; k <= 6; k++) begin
      tick(1);
      check("R8 toggle/set waves", {13'b0, waveOut},
            {13'b0, (k >= 6), (k >= 4), (k >= 3)});
    end
    rd(FLAG, rv); check("R7 compare flags", rv, 16'h000E);
    wr(CTLA, 16'h0); wr(FLAG, 16'h1F); wr(CNT, 16'h3);
    rd(FLAG, rv); check("R7 write gives no match", rv, 16'h0000);
    wr(CTLB, 16'h0018); wr(CNT, 16'h0); wr(CTLA, 16'h0001);
    for (int k = 1; k <= 6; k++) begin
      tick(1);
      check("R8 off/clear/toggle waves", {13'b0, waveOut},
            {13'b0, (k < 6), (k < 4), 1'b0});
    end
    wr(CTLB, 16'h0019);
    check("R8 disconnect keeps state", {13'b0, waveOut}, 16'h0001);

    // R9 capture polarity and source
    wr(CTLA, 16'h0); wr(CTLB, 16'h0080); wr(FLAG, 16'h1F); wr(CNT, 16'h1234);
    pulseCap(0, 6);
    rd(CAP, rv); check("R9 rising pin capture", rv, 16'h1234);
    rd(FLAG, rv); check("R9 capture flag", rv, 16'h0010);
    wr(CTLB, 16'h0000); wr(FLAG, 16'h1F); wr(CNT, 16'h0456);
    @(negedge clk) capPin = 1'b1; idle(10);
    rd(CAP, rv); check("R9 rise ignored in falling mode", rv, 16'h1234);
    wr(CNT, 16'h0789);
    @(negedge clk) capPin = 1'b0; idle(10);
    rd(CAP, rv); check("R9 falling pin capture", rv, 16'h0789);
    wr(CTLB, 16'h00C0); wr(CNT, 16'h0ABC);
    pulseCap(0, 6);
    rd(CAP, rv); check("R9 pin ignored with comparator source", rv, 16'h0789);
    pulseCap(1, 6);
    rd(CAP, rv); check("R9 comparator capture", rv, 16'h0ABC);

    // R10 noise filter
    wr(CTLB, 16'h0080); wr(CTLA, 16'h0020); wr(FLAG, 16'h1F); wr(CNT, 16'h0111);
    pulseCap(0, 3);
    rd(CAP, rv); check("R10 short pulse rejected", rv, 16'h0ABC);
    rd(FLAG, rv); check("R10 no flag on short pulse", rv, 16'h0000);
    pulseCap(0, 6);
    rd(CAP, rv); check("R10 long pulse accepted", rv, 16'h0111);
    wr(CTLA, 16'h0000); wr(CNT, 16'h0222);
    pulseCap(0, 2);
    rd(CAP, rv); check("R10 unfiltered short pulse", rv, 16'h0222);

    // R11 write-one-to-clear
    wr(FLAG, 16'h0000); rd(FLAG, rv); check("R11 write zero keeps", rv, 16'h0010);
    wr(FLAG, 16'h000F); rd(FLAG, rv); check("R11 other bits kept", rv, 16'h0010);
    wr(FLAG, 16'h0010); idle(5);
    rd(FLAG, rv); check("R11 cleared stays clear", rv, 16'h0000);

    // R12 masked interrupt
    wr(CNT, 16'hFFFF); wr(CTLA, 16'h0001); tick(1); wr(CTLA, 16'h0);
    check("R12 unmasked flag no irq", {15'b0, irq}, 16'h0);
    wr(MASK, 16'h0001); check("R12 masked flag irq", {15'b0, irq}, 16'h1);
    wr(MASK, 16'h001E); check("R12 other mask no irq", {15'b0, irq}, 16'h0);
    wr(MASK, 16'h0001); wr(FLAG, 16'h0001);
    check("R12 cleared flag drops irq", {15'b0, irq}, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule